// File: doc/BRIEF.md
# Debug System Bus Access Engine

This block lets an external debugger reach system memory through a handful of 32-bit registers on a plain register port. The port carries an address, write data, a write strobe and a read strobe. Read data is registered and is valid in the cycle after the read strobe. The registers are one control/status word, four address words that together form a 128-bit address, and four data words. Bus transfers are never started directly. Each one is a side effect of a register access:
- writing address word 0 can start a read;
- reading data word 0 can advance the address and start a read;
- writing data word 0 starts a write.

Each transfer is a single 8, 16, 32 or 64-bit access on a request/ready/error memory port. The request is held until the memory side answers. A sticky 3-bit error code, cleared by writing ones, blocks every further transfer until software clears it. A rising edge on the activation input puts all engine state back to reset values. This includes any transfer in flight.

Top module: `sbx_engine`

## Requirements
- R1: The register map is: 0x37 address word 3 (address bits 127:96), 0x38 control, 0x39/0x3A/0x3B address words 0/1/2, 0x3C..0x3F data words 0..3. The control word reads back version 1 in bits 31:29, busy in bit 21, read-on-address in bit 20, size in bits 19:17, auto-increment in bit 16, read-on-data in bit 15, error in bits 14:12, address width 64 in bits 11:5, a 0 in bit 4 (no 128-bit access) and ones in bits 3:0 (8/16/32/64-bit access). After reset the control word reads 0x2000080F and all other registers read 0.
- R2: When the error code is 0 and read-on-address is set, a write to address word 0 stores the value and starts a read at {address word 1, new value}. The read moves 1<<size bytes (size 0..3). A narrow read is zero-extended into data word 0. A 64-bit read puts the low half in data word 0 and the high half in data word 1.
- R3: A read of data word 0 returns its contents before any side effect. If the error code is 0, the read then adds the step to the address when auto-increment is set. It then starts a bus read at the resulting address when read-on-data is set. When read-on-data is clear, no bus access starts.
- R4: When the error code is 0, a write to data word 0 stores the value and starts a bus write. The low half comes from the new data word 0 and the high half from data word 1. If auto-increment is set and the write completes without a fault, the address then advances by the step.
- R5: The step is 1<<size bytes. It is added to address word 0, and the carry ripples through words 1, 2 and 3.
- R6: A size value above 3 starts no bus access when a transfer would be triggered, and sets the error code to 3.
- R7: A fault answer from memory sets the error code to 2. A faulted access updates neither the data words nor the address.
- R8: Writing the control word clears the error bits written as 1 and leaves the others: new = old & ~written. Writes never set error bits. While the error code is nonzero, register accesses start no bus access.
- R9: While a transfer is outstanding, busy reads 1. A register access that would start a transfer or advance the address in that time has no effect, and it sets the error code to 4.
- R10: A 0-to-1 change of the activation input returns every register to its reset value and drops any outstanding request.
- R11: A request stays asserted with a stable address until ready is seen, then drops for at least one cycle. Each trigger produces exactly one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dm_active | input | 1 | Activation level; a rising edge clears all state |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| mem_req | output | 1 | Memory request, held until mem_ready |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 64 | Byte address |
| mem_size | output | 2 | log2 of the access size in bytes |
| mem_wdata | output | 64 | Write data, low bytes significant |
| mem_ready | input | 1 | Memory answers the current request |
| mem_rdata | input | 64 | Read data, valid with mem_ready |
| mem_err | input | 1 | Fault answer, valid with mem_ready |

## Verification
The main function is tried with each of the four access sizes against a memory whose bytes equal their own offsets. A wrong mask, lane or byte order therefore shows up as a different value. Writes are read back through the engine itself, which separates a lost high half from a lost low half. A stream of reads with read-on-data and auto-increment set separates read-then-advance from advance-then-read. A carry test starts at an address of all ones below the top word, so a carry break at any word boundary is seen. The error tests cover:
- an illegal size;
- a fault address;
- a busy collision, with a slowed memory;
- partial write-one-to-clear, which tells the three error codes apart.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
  localparam int REG_W = 32;

  typedef enum logic [0:0] {BP_IDLE, BP_WAIT} bp_state_e;

  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_FAULT = 3'd2;
  localparam logic [2:0] ERR_SIZE  = 3'd3;
  localparam logic [2:0] ERR_BUSY  = 3'd4;

  localparam int CTL_VER_LO  = 29;
  localparam int CTL_BUSY    = 21;
  localparam int CTL_RONA    = 20;
  localparam int CTL_SIZE_LO = 17;
  localparam int CTL_AUTO    = 16;
  localparam int CTL_ROND    = 15;
  localparam int CTL_ERR_LO  = 12;
  localparam int CTL_ASZ_LO  = 5;
endpackage

// File: rtl/sbx_addr_adv.sv
module sbx_addr_adv #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic [WORDS*WORD_W-1:0] base_i,
  input  logic [2:0]              size_i,
  output logic [WORDS*WORD_W-1:0] next_o
);
  localparam int TOT_W = WORDS * WORD_W;

  logic [TOT_W-1:0] step;

  // step in bytes is 1 << size; the wide add ripples the carry through every word
  assign step   = TOT_W'(1) << size_i;
  assign next_o = base_i + step;
endmodule

// File: rtl/sbx_bus_port.sv
module sbx_bus_port
  import sbx_pkg::*;
#(
  parameter int AW = 64,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          start,
  input  logic          start_we,
  input  logic [1:0]    start_size,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          done,
  output logic          done_err,
  output logic [DW-1:0] rdata_ext
);
  bp_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      state_q   <= BP_IDLE;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_size  <= '0;
      mem_wdata <= '0;
    end else begin
      unique case (state_q)
        BP_IDLE: if (start) begin
          state_q   <= BP_WAIT;
          mem_we    <= start_we;
          mem_addr  <= start_addr;
          mem_size  <= start_size;
          mem_wdata <= start_wdata;
        end
        BP_WAIT: if (mem_ready) state_q <= BP_IDLE;
        default: state_q <= BP_IDLE;
      endcase
    end
  end

  assign mem_req  = (state_q == BP_WAIT);
  assign busy     = mem_req;
  assign done     = mem_req & mem_ready;
  assign done_err = mem_err;

  always_comb begin
    unique case (mem_size)
      2'd0:    rdata_ext = DW'(mem_rdata[7:0]);
      2'd1:    rdata_ext = DW'(mem_rdata[15:0]);
      2'd2:    rdata_ext = DW'(mem_rdata[31:0]);
      default: rdata_ext = mem_rdata;
    endcase
  end
endmodule

// File: rtl/sbx_engine.sv
module sbx_engine
  import sbx_pkg::*;
#(
  parameter int            RA_W     = 7,
  parameter logic [RA_W-1:0] RA_ADDR3 = 7'h37,
  parameter logic [RA_W-1:0] RA_CTRL  = 7'h38,
  parameter logic [RA_W-1:0] RA_ADDR0 = 7'h39,
  parameter logic [RA_W-1:0] RA_DATA0 = 7'h3C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dm_active,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             reg_wr,
  input  logic             reg_rd,
  output logic [REG_W-1:0] reg_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [63:0]      mem_addr,
  output logic [1:0]       mem_size,
  output logic [63:0]      mem_wdata,
  input  logic             mem_ready,
  input  logic [63:0]      mem_rdata,
  input  logic             mem_err
);
  localparam int NWORDS = 4;
  localparam int BUS_W  = 2 * REG_W;
  localparam int AREG_W = NWORDS * REG_W;

  // engine state
  logic [AREG_W-1:0] addr_q;
  logic [REG_W-1:0]  data_q [NWORDS];
  logic              rona_q, auto_q, rond_q, active_q;
  logic [2:0]        size_q, err_q;

  // bus port interface
  logic              busy, done, done_err, start;
  logic [BUS_W-1:0]  start_addr, rdata_ext;
  logic [AREG_W-1:0] addr_adv;
  logic [2:0]        adv_size;

  // decode
  logic       act_rise, hit_ctrl, a_hit, d_hit;
  logic [1:0] a_idx, d_idx;
  logic       wr_a0, rd_d0, wr_d0;
  logic       err_ok, size_ok, trig_a0, trig_rd, trig_wr, want, step_rd, busy_hit, bad_size;
  logic [REG_W-1:0] ctrl_word, rd_mux;

  assign act_rise = dm_active & ~active_q;
  assign hit_ctrl = (reg_addr == RA_CTRL);
  assign d_hit    = (reg_addr[RA_W-1:2] == RA_DATA0[RA_W-1:2]);
  assign d_idx    = reg_addr[1:0];

  always_comb begin
    a_hit = 1'b1;
    a_idx = 2'd0;
    if (reg_addr == RA_ADDR0)                   a_idx = 2'd0;
    else if (reg_addr == RA_ADDR0 + RA_W'(1))   a_idx = 2'd1;
    else if (reg_addr == RA_ADDR0 + RA_W'(2))   a_idx = 2'd2;
    else if (reg_addr == RA_ADDR3)              a_idx = 2'd3;
    else                                        a_hit = 1'b0;
  end

  assign wr_a0 = reg_wr & a_hit & (a_idx == 2'd0);
  assign rd_d0 = reg_rd & d_hit & (d_idx == 2'd0);
  assign wr_d0 = reg_wr & d_hit & (d_idx == 2'd0);

  // trigger rules
  assign err_ok   = (err_q == ERR_NONE);
  assign size_ok  = ~size_q[2];
  assign trig_a0  = wr_a0 & rona_q & err_ok;
  assign trig_rd  = rd_d0 & rond_q & err_ok;
  assign trig_wr  = wr_d0 & err_ok;
  assign want     = trig_a0 | trig_rd | trig_wr;
  assign step_rd  = rd_d0 & auto_q & err_ok;
  assign busy_hit = (want | step_rd) & busy;
  assign bad_size = want & ~busy & ~size_ok;
  assign start    = want & ~busy & size_ok;

  // a completing write advances by its own latched size; otherwise the current size field
  assign adv_size = done ? {1'b0, mem_size} : size_q;

  sbx_addr_adv #(.WORD_W(REG_W), .WORDS(NWORDS)) u_adv (
    .base_i (addr_q),
    .size_i (adv_size),
    .next_o (addr_adv)
  );

  always_comb begin
    if (trig_a0)              start_addr = {addr_q[REG_W +: REG_W], reg_wdata};
    else if (trig_rd && auto_q) start_addr = addr_adv[BUS_W-1:0];
    else                      start_addr = addr_q[BUS_W-1:0];
  end

  sbx_bus_port #(.AW(BUS_W), .DW(BUS_W)) u_bus (
    .clk         (clk),
    .rst         (rst),
    .flush       (act_rise),
    .start       (start),
    .start_we    (trig_wr),
    .start_size  (size_q[1:0]),
    .start_addr  (start_addr),
    .start_wdata ({data_q[1], reg_wdata}),
    .mem_ready   (mem_ready),
    .mem_rdata   (mem_rdata),
    .mem_err     (mem_err),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_size    (mem_size),
    .mem_wdata   (mem_wdata),
    .busy        (busy),
    .done        (done),
    .done_err    (done_err),
    .rdata_ext   (rdata_ext)
  );

  always_ff @(posedge clk) begin
    if (rst) active_q <= 1'b0;
    else     active_q <= dm_active;
  end

  always_ff @(posedge clk) begin
    if (rst || act_rise) begin
      addr_q <= '0;
      for (int i = 0; i < NWORDS; i++) data_q[i] <= '0;
      rona_q <= 1'b0;
      auto_q <= 1'b0;
      rond_q <= 1'b0;
      size_q <= '0;
      err_q  <= ERR_NONE;
    end else begin
      if (reg_wr && !busy_hit) begin
        if (hit_ctrl) begin
          rona_q <= reg_wdata[CTL_RONA];
          size_q <= reg_wdata[CTL_SIZE_LO +: 3];
          auto_q <= reg_wdata[CTL_AUTO];
          rond_q <= reg_wdata[CTL_ROND];
          err_q  <= err_q & ~reg_wdata[CTL_ERR_LO +: 3];
        end
        if (a_hit) addr_q[a_idx*REG_W +: REG_W] <= reg_wdata;
        if (d_hit) data_q[d_idx] <= reg_wdata;
      end
      if (step_rd && !busy) addr_q <= addr_adv;
      if (busy_hit)      err_q <= ERR_BUSY;
      else if (bad_size) err_q <= ERR_SIZE;
      if (done) begin
        if (done_err) begin
          err_q <= ERR_FAULT;
        end else if (!mem_we) begin
          data_q[0] <= rdata_ext[REG_W-1:0];
          if (mem_size == 2'd3) data_q[1] <= rdata_ext[BUS_W-1:REG_W];
        end else if (auto_q) begin
          addr_q <= addr_adv;
        end
      end
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTL_VER_LO +: 3]  = 3'd1;
    ctrl_word[CTL_BUSY]         = busy;
    ctrl_word[CTL_RONA]         = rona_q;
    ctrl_word[CTL_SIZE_LO +: 3] = size_q;
    ctrl_word[CTL_AUTO]         = auto_q;
    ctrl_word[CTL_ROND]         = rond_q;
    ctrl_word[CTL_ERR_LO +: 3]  = err_q;
    ctrl_word[CTL_ASZ_LO +: 7]  = 7'(BUS_W);
    ctrl_word[3:0]              = 4'hF;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)   rd_mux = ctrl_word;
    else if (a_hit) rd_mux = addr_q[a_idx*REG_W +: REG_W];
    else if (d_hit) rd_mux = data_q[d_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/sbx_engine_chk.sv
module sbx_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        dm_active,
  input logic        mem_req,
  input logic        mem_ready,
  input logic        mem_err,
  input logic [63:0] mem_addr,
  input logic [2:0]  err_q
);
  logic prev_act;
  logic act_rise;

  always_ff @(posedge clk) begin
    if (rst) prev_act <= 1'b0;
    else     prev_act <= dm_active;
  end
  assign act_rise = dm_active & ~prev_act;

  // R11: request and address hold until answered
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready && !act_rise) |=> (mem_req && $stable(mem_addr)));

  // R11: a request drops right after its answer
  assert_one_shot_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready) |=> !mem_req);

  // R8: no access begins while an error is pending
  assert_start_clean_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> ($past(err_q) == 3'd0));

  // R7: a fault answer leaves error code 2
  assert_fault_code_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready && mem_err && !act_rise) |=> (err_q == 3'd2));

  // R10: activation clears error and request
  assert_act_clear_R10: assert property (@(posedge clk) disable iff (rst)
    act_rise |=> (!mem_req && err_q == 3'd0));
endmodule

bind sbx_engine sbx_engine_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .dm_active (dm_active),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_err   (mem_err),
  .mem_addr  (mem_addr),
  .err_q     (err_q)
);

// File: tb/sbx_engine_test.sv
module sbx_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dm_active = 1'b1;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic        mem_ready = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        mem_err = 1'b0;

  int total = 0;
  int bad = 0;
  int lat = 2;
  int wait_n = 0;
  int n_req = 0;
  logic req_prev = 1'b0;
  logic [7:0] mem [256];

  always #5 clk = ~clk;

  sbx_engine uut (
    .clk(clk), .rst(rst), .dm_active(dm_active),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_err(mem_err)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i);

  // memory model: answers after lat falling edges; upper address word nonzero faults
  always @(negedge clk) begin
    if (mem_req && !req_prev) n_req++;
    req_prev = mem_req;
    if (mem_req && !mem_ready) begin
      wait_n++;
      if (wait_n >= lat) begin
        mem_ready = 1'b1;
        mem_err   = (mem_addr[63:32] != 32'h0);
        for (int k = 0; k < 8; k++) mem_rdata[8*k +: 8] = mem[mem_addr[7:0] + 8'(k)];
        if (mem_we && !mem_err)
          for (int k = 0; k < (1 << mem_size); k++) mem[mem_addr[7:0] + 8'(k)] = mem_wdata[8*k +: 8];
        wait_n = 0;
      end
    end else begin
      mem_ready = 1'b0;
      mem_err   = 1'b0;
      wait_n    = 0;
    end
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  typedef struct packed {
    logic        is_wr;
    logic [6:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 7'h38, 32'h00140000, 32'h0,        4'd2},  // R2 size 2, read on address
    '{1'b0, 7'h38, 32'h0,        32'h2014080F, 4'd1},  // R1 readback
    '{1'b1, 7'h39, 32'h00000010, 32'h0,        4'd2},
    '{1'b0, 7'h3C, 32'h0,        32'h13121110, 4'd2},  // R2 32-bit
    '{1'b0, 7'h3D, 32'h0,        32'h00000000, 4'd2},
    '{1'b1, 7'h38, 32'h00100000, 32'h0,        4'd2},  // size 0
    '{1'b1, 7'h39, 32'h00000021, 32'h0,        4'd2},
    '{1'b0, 7'h3C, 32'h0,        32'h00000021, 4'd2},  // R2 zero-extended byte
    '{1'b1, 7'h38, 32'h00120000, 32'h0,        4'd2},
    '{1'b1, 7'h39, 32'h00000030, 32'h0,        4'd2},
    '{1'b0, 7'h3C, 32'h0,        32'h00003130, 4'd2},  // R2 halfword
    '{1'b1, 7'h38, 32'h00160000, 32'h0,        4'd2},
    '{1'b1, 7'h39, 32'h00000040, 32'h0,        4'd2},
    '{1'b0, 7'h3C, 32'h0,        32'h43424140, 4'd2},  // R2 64-bit low
    '{1'b0, 7'h3D, 32'h0,        32'h47464544, 4'd2},  // R2 64-bit high
    '{1'b1, 7'h38, 32'h00050000, 32'h0,        4'd4},  // R4 size 2, auto-increment
    '{1'b1, 7'h39, 32'h00000080, 32'h0,        4'd4},
    '{1'b1, 7'h3C, 32'hDEADBEEF, 32'h0,        4'd4},
    '{1'b0, 7'h39, 32'h0,        32'h00000084, 4'd4},  // R4 advance after write
    '{1'b1, 7'h3C, 32'h01020304, 32'h0,        4'd4},
    '{1'b0, 7'h39, 32'h0,        32'h00000088, 4'd5},  // R5 step of 4
    '{1'b1, 7'h38, 32'h00140000, 32'h0,        4'd4},
    '{1'b1, 7'h39, 32'h00000080, 32'h0,        4'd4},
    '{1'b0, 7'h3C, 32'h0,        32'hDEADBEEF, 4'd4},  // R4 written data reaches memory
    '{1'b1, 7'h39, 32'h00000084, 32'h0,        4'd4},
    '{1'b0, 7'h3C, 32'h0,        32'h01020304, 4'd4},
    '{1'b1, 7'h38, 32'h00158000, 32'h0,        4'd3},  // R3 read on data + auto-increment
    '{1'b1, 7'h39, 32'h00000020, 32'h0,        4'd3},
    '{1'b0, 7'h3C, 32'h0,        32'h23222120, 4'd3},
    '{1'b0, 7'h3C, 32'h0,        32'h27262524, 4'd3},  // R3 advance then read
    '{1'b0, 7'h39, 32'h0,        32'h00000028, 4'd3}
  };

  logic finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(7'h38, v); chk("R1 reset ctrl", v, 32'h2000080F);
    rd(7'h39, v); chk("R1 reset addr0", v, 32'h0);
    rd(7'h3C, v); chk("R1 reset data0", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_wr) wr(VEC[i].a, VEC[i].d);
      else begin
        rd(VEC[i].a, v);
        total++;
        if (v !== VEC[i].e) begin
          bad++;
          $display("FAIL R%0d vector %0d: got %08h expected %08h", VEC[i].req, i, v, VEC[i].e);
        end
      end
      settle();
    end

    // R4 64-bit write, halves from data words 0 and 1
    wr(7'h38, 32'h00070000); wr(7'h3A, 32'h0); wr(7'h39, 32'h90);
    wr(7'h3D, 32'hCAFEF00D); wr(7'h3C, 32'h11223344); settle();
    rd(7'h39, v); chk("R4 advance by 8", v, 32'h98);
    wr(7'h38, 32'h00160000); wr(7'h39, 32'h90); settle();
    rd(7'h3C, v); chk("R4 low half", v, 32'h11223344);
    rd(7'h3D, v); chk("R4 high half", v, 32'hCAFEF00D);

    // R5 carry through all words; R3 no access without read-on-data
    wr(7'h38, 32'h00070000); wr(7'h39, 32'hFFFFFFF8);
    wr(7'h3A, 32'hFFFFFFFF); wr(7'h3B, 32'hFFFFFFFF); wr(7'h37, 32'h0);
    n0 = n_req;
    rd(7'h3C, v); settle();
    rd(7'h37, v); chk("R5 carry into word 3", v, 32'h1);
    rd(7'h39, v); chk("R5 word 0 wraps", v, 32'h0);
    rd(7'h3A, v); chk("R5 word 1 wraps", v, 32'h0);
    rd(7'h3B, v); chk("R5 word 2 wraps", v, 32'h0);
    chk("R3 no bus read", 32'(n_req - n0), 32'h0);
    wr(7'h3A, 32'h0); wr(7'h37, 32'h0);

    // R6 illegal size
    wr(7'h38, 32'h001A0000);
    n0 = n_req;
    wr(7'h39, 32'h10); settle();
    rd(7'h38, v); chk("R6 error 3", v, 32'h201A380F);
    chk("R6 no request", 32'(n_req - n0), 32'h0);
    // R8 sticky, partial clear, no set
    wr(7'h38, 32'h00140000);
    rd(7'h38, v); chk("R8 zero bits keep error", v, 32'h2014380F);
    n0 = n_req;
    wr(7'h39, 32'h10); settle();
    chk("R8 error blocks access", 32'(n_req - n0), 32'h0);
    wr(7'h38, 32'h00141000);
    rd(7'h38, v); chk("R8 partial clear", v, 32'h2014280F);
    wr(7'h38, 32'h00147000);
    rd(7'h38, v); chk("R8 full clear", v, 32'h2014080F);
    wr(7'h38, 32'h00144000);
    rd(7'h38, v); chk("R8 cannot set", v, 32'h2014080F);

    // R7 bus fault on read and on write
    wr(7'h3A, 32'h1); wr(7'h39, 32'h44); settle();
    rd(7'h38, v); chk("R7 error 2", v, 32'h2014280F);
    rd(7'h3C, v); chk("R7 data untouched", v, 32'h11223344);
    wr(7'h38, 32'h00052000);
    wr(7'h3C, 32'h5); settle();
    rd(7'h39, v); chk("R7 no advance on fault", v, 32'h44);
    rd(7'h38, v); chk("R7 write fault", v, 32'h2005280F);
    wr(7'h38, 32'h00142000); wr(7'h3A, 32'h0);

    // R9 collision while busy; R11 one request
    lat = 12;
    n0 = n_req;
    wr(7'h39, 32'h10);
    rd(7'h38, v); chk("R9 busy bit", v, 32'h2034080F);
    wr(7'h39, 32'h20);
    rd(7'h38, v); chk("R9 error 4", v, 32'h2034480F);
    repeat (24) @(negedge clk);
    rd(7'h39, v); chk("R9 write ignored", v, 32'h10);
    rd(7'h3C, v); chk("R9 first read lands", v, 32'h13121110);
    rd(7'h38, v); chk("R9 idle with error 4", v, 32'h2014480F);
    chk("R11 one request", 32'(n_req - n0), 32'h1);
    lat = 2;
    wr(7'h38, 32'h00144000);

    // R10 activation edge clears state
    wr(7'h39, 32'h55);
    dm_active = 1'b0; @(negedge clk);
    dm_active = 1'b1; repeat (2) @(negedge clk);
    rd(7'h39, v); chk("R10 addr cleared", v, 32'h0);
    rd(7'h38, v); chk("R10 ctrl cleared", v, 32'h2000080F);
    rd(7'h3C, v); chk("R10 data cleared", v, 32'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule